// File: doc/BRIEF.md
# Colour-Phased Stochastic Spin Array

This block holds a small population of stochastic binary units, each carrying a spin of +1 or −1 on a sparse, programmable graph. Every unit keeps a short list of neighbours with signed coupling weights, plus a signed bias and a colour tag. When its colour is active, the unit forms the local field (bias plus the weighted sum of the neighbours' spins). It scales that field by an inverse-temperature input and passes the result through a saturating hyperbolic-tangent table. It then sets its spin to +1 when the table output exceeds a fresh signed random draw from its own shift-register generator.

A controller walks the colour classes in ascending order, one class per clock cycle. All units of the active class commit together. Units of a later class therefore see the values committed by earlier classes in the same pass. One pass over every class is one sweep, so a sweep takes as many cycles as there are colours, whatever the array size. Software loads the graph through a write port, applies the colour count and the inverse temperature, pulses a start input, and reads the spin vector once the done pulse arrives. An external controller owns the colouring and any annealing or tempering schedule.

Top module: `pbit_array`

## Requirements
- R1: After reset every spin reads +1 (spin bit 1 means +1, 0 means −1), busy is low and sweep_done is low.
- R2: A configuration write with cfg_is_unit=1 sets the addressed unit's bias, colour and spin, and the new spin is visible on `spins` in the cycle after the write edge. A write with cfg_is_unit=0 sets the neighbour index and weight of slot cfg_slot. Slots at or above MAX_NBR are ignored.
- R3: Suppose sweep_start is sampled high at edge k while idle, with num_colours = C (1..N_COL). Then busy is high from edge k to edge k+C. sweep_done is high for exactly one cycle, following edge k+C, and busy falls at that same edge.
- R4: While busy, both sweep_start and configuration writes are ignored. The sweep still ends after C cycles, and the stored spins and configuration are unchanged by the write.
- R5: Colour classes commit in ascending order 0..C−1, one per cycle. A unit reads its neighbours' spins as they stand at the start of its own class's cycle.
- R6: The local field is bias + Σ(±weight), taking +weight for a neighbour with spin +1 and −weight for spin −1.
- R7: With beta holding BETA_FRAC fractional bits, suppose the scaled field beta·I is at least +4.0. Then the committed spin is +1. If beta·I is at most −4.0, it is −1.
- R8: The scaled field is clamped to the symmetric range of a signed value with 6 integer bits and FRAC fractional bits. A field far beyond that range still resolves to the sign of the field and never wraps.
- R9: When the scaled field is zero, the update is a fair coin (P(+1) = 1/2). When it is +1.0, P(+1) is 225/256, from a table output of 97 out of 128 compared against a uniform 8-bit signed draw.
- R10: A unit whose colour is not below num_colours never changes its spin during a sweep.
- R11: Each unit draws from its own generator with a distinct non-zero seed, so two units given identical zero fields evolve differently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_is_unit | input | 1 | 1: write bias/colour/spin; 0: write a neighbour slot |
| cfg_unit | input | IW | Addressed unit |
| cfg_slot | input | SW | Neighbour slot for a slot write |
| cfg_nbr | input | IW | Neighbour unit index for a slot write |
| cfg_weight | input | WW | Signed coupling weight for a slot write |
| cfg_bias | input | HW | Signed bias for a unit write |
| cfg_colour | input | CW | Colour tag for a unit write |
| cfg_spin | input | 1 | Preset spin for a unit write |
| num_colours | input | CW+1 | Number of colour classes per sweep |
| beta | input | BETA_W | Unsigned inverse temperature, BETA_FRAC fractional bits |
| sweep_start | input | 1 | Start pulse, honoured only when idle |
| busy | output | 1 | Sweep in progress |
| sweep_done | output | 1 | One-cycle pulse after the last class commits |
| spins | output | N_UNITS | Current spins, bit i for unit i |

## Verification
The embedded properties rely on a few conditions from the environment. The colouring must be proper, so no two neighbours share a class. num_colours must lie between 1 and N_COL. beta and the loaded graph must stay fixed for the length of a sweep. The stimulus loads every graph while idle, uses ring graphs coloured by index modulo the colour count, and changes beta only between sweeps. Deterministic checks choose even weights and odd biases with a large beta, so every field is non-zero and saturated and the outcome is a pure sign. The stochastic checks accept only wide bands around the expected probabilities.

// File: rtl/pbit_pkg.sv
// Shared constants and the tanh table for the stochastic spin array.
// Assumes the random draw is RND_W = 8 bits, so tanh full scale is 128.
package pbit_pkg;
    localparam int RND_W    = 8;
    localparam int TANH_TOP = 128;
    localparam int TAB_FRAC = 3;   // table step is 1/8

    // tanh(idx/8) scaled to 128, rounded; saturates to 128 beyond 3.0
    function automatic logic [RND_W:0] tanh_q(input logic [15:0] idx);
        logic [RND_W:0] v;
        case (idx)
            16'd0:  v = 9'd0;
            16'd1:  v = 9'd16;
            16'd2:  v = 9'd31;
            16'd3:  v = 9'd46;
            16'd4:  v = 9'd59;
            16'd5:  v = 9'd71;
            16'd6:  v = 9'd81;
            16'd7:  v = 9'd90;
            16'd8:  v = 9'd97;
            16'd9:  v = 9'd104;
            16'd10: v = 9'd109;
            16'd11: v = 9'd113;
            16'd12: v = 9'd116;
            16'd13: v = 9'd118;
            16'd14: v = 9'd120;
            16'd15: v = 9'd122;
            16'd16: v = 9'd123;
            16'd17: v = 9'd124;
            16'd18: v = 9'd125;
            16'd19: v = 9'd126;
            16'd20: v = 9'd126;
            16'd21: v = 9'd127;
            16'd22: v = 9'd127;
            16'd23: v = 9'd127;
            16'd24: v = 9'd127;
            default: v = 9'd128;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/pbit_lfsr.sv
// 16-bit Galois shift register, one step per cycle, as a per-unit random source.
// Assumes SEED is non-zero; exposes the low OUT_W bits as a signed draw.
module pbit_lfsr #(
    parameter logic [15:0] SEED  = 16'hACE1,
    parameter int          OUT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd
);
    localparam logic [15:0] TAPS = 16'hB400;

    logic [15:0] state_q;

    // advance the register every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= (state_q >> 1) ^ (state_q[0] ? TAPS : 16'h0000);
    end

    assign rnd = state_q[OUT_W-1:0];

    // R11
    lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 16'h0000);
endmodule

// File: rtl/pbit_field.sv
// Local field, beta scaling and clamp for one unit.
// Assumes neighbour indices address existing units; unused slots carry weight 0.
module pbit_field #(
    parameter int N_UNITS   = 8,
    parameter int MAX_NBR   = 6,
    parameter int WW        = 4,
    parameter int HW        = 6,
    parameter int BETA_W    = 8,
    parameter int BETA_FRAC = 4,
    parameter int FRAC      = 3,
    localparam int IW       = $clog2(N_UNITS),
    localparam int XW       = 7 + FRAC
) (
    input  logic [N_UNITS-1:0]          spins_in,
    input  logic [MAX_NBR-1:0][IW-1:0]  nbr_idx,
    input  logic [MAX_NBR-1:0][WW-1:0]  nbr_w,
    input  logic [HW-1:0]               bias,
    input  logic [BETA_W-1:0]           beta,
    output logic signed [XW-1:0]        x
);
    localparam int FMAX = MAX_NBR * (2 ** (WW - 1)) + 2 ** (HW - 1);
    localparam int FW   = $clog2(FMAX + 1) + 1;
    localparam int PW   = FW + BETA_W + 1;
    localparam int LSH  = (FRAC > BETA_FRAC) ? FRAC - BETA_FRAC : 0;
    localparam int RSH  = (BETA_FRAC > FRAC) ? BETA_FRAC - FRAC : 0;
    localparam int SHW  = PW + LSH;
    localparam int XMAX = 2 ** (6 + FRAC) - 1;
    localparam logic signed [SHW-1:0] HI = SHW'(XMAX);
    localparam logic signed [SHW-1:0] LO = -HI;

    logic signed [FW-1:0]  acc;
    logic signed [PW-1:0]  prod;
    logic signed [SHW-1:0] scaled;

    // sum signed neighbour contributions onto the bias
    always_comb begin
        acc = FW'($signed(bias));
        for (int k = 0; k < MAX_NBR; k++) begin
            if (spins_in[nbr_idx[k]]) acc = acc + FW'($signed(nbr_w[k]));
            else                      acc = acc - FW'($signed(nbr_w[k]));
        end
    end

    // scale by beta, align to FRAC fractional bits, clamp symmetrically
    always_comb begin
        prod   = PW'(acc) * PW'($signed({1'b0, beta}));
        scaled = (SHW'(prod) <<< LSH) >>> RSH;
        if (scaled > HI)      x = XW'(XMAX);
        else if (scaled < LO) x = -XW'(XMAX);
        else                  x = scaled[XW-1:0];
    end
endmodule

// File: rtl/pbit_tanh.sv
// Saturating tanh of the clamped scaled field, odd-symmetric.
// Assumes FRAC >= 3 and a symmetric input range (no most-negative code).
module pbit_tanh #(
    parameter int FRAC = 3,
    localparam int XW  = 7 + FRAC
) (
    input  logic signed [XW-1:0]             x,
    output logic signed [pbit_pkg::RND_W:0]  t
);
    import pbit_pkg::*;

    logic              neg;
    logic [XW-1:0]     mag;
    logic [15:0]       idx;
    logic [RND_W:0]    v;

    // fold to magnitude, look up at 1/8 steps, restore the sign
    always_comb begin
        neg = x[XW-1];
        mag = neg ? XW'(-x) : XW'(x);
        idx = 16'(mag >> (FRAC - TAB_FRAC));
        v   = tanh_q(idx);
        t   = neg ? -$signed(v) : $signed(v);
    end
endmodule

// File: rtl/pbit_seq.sv
// Colour-phase controller: steps classes 0..C-1, one per cycle, then pulses done.
// Assumes num_colours in 1..N_COL; 0 is treated as 1, larger values as N_COL.
module pbit_seq #(
    parameter int  N_COL = 4,
    localparam int CW    = $clog2(N_COL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sweep_start,
    input  logic [CW:0]   num_colours,
    output logic          busy,
    output logic [CW-1:0] phase,
    output logic          sweep_done
);
    logic [CW-1:0] last_q;
    logic [CW-1:0] last_d;

    // map the requested colour count onto the final phase index
    always_comb begin
        if (num_colours == '0)                      last_d = '0;
        else if (num_colours > (CW+1)'(N_COL))      last_d = CW'(N_COL - 1);
        else                                        last_d = CW'(num_colours - 1'b1);
    end

    // accept start when idle, advance phases, pulse done after the last
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            phase      <= '0;
            last_q     <= '0;
            sweep_done <= 1'b0;
        end else begin
            sweep_done <= 1'b0;
            if (!busy) begin
                if (sweep_start) begin
                    busy   <= 1'b1;
                    phase  <= '0;
                    last_q <= last_d;
                end
            end else if (phase == last_q) begin
                busy       <= 1'b0;
                sweep_done <= 1'b1;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |=> !sweep_done);
    // R3
    done_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> sweep_done);
    // R4
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sweep_start) |=> (last_q == $past(last_q)));
    // R5
    phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (phase <= last_q));
endmodule

// File: rtl/pbit_unit.sv
// One stochastic spin unit: stores its graph entry, draws and commits on its phase.
// Assumes config writes arrive only while idle (writes during busy are dropped).
module pbit_unit #(
    parameter int          ID        = 0,
    parameter int          N_UNITS   = 8,
    parameter int          MAX_NBR   = 6,
    parameter int          N_COL     = 4,
    parameter int          WW        = 4,
    parameter int          HW        = 6,
    parameter int          BETA_W    = 8,
    parameter int          BETA_FRAC = 4,
    parameter int          FRAC      = 3,
    parameter logic [15:0] SEED      = 16'hACE1,
    localparam int IW = $clog2(N_UNITS),
    localparam int SW = $clog2(MAX_NBR),
    localparam int CW = $clog2(N_COL),
    localparam int XW = 7 + FRAC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_UNITS-1:0] spins_in,
    input  logic               busy,
    input  logic [CW-1:0]      phase,
    input  logic [BETA_W-1:0]  beta,
    input  logic               cfg_we,
    input  logic               cfg_is_unit,
    input  logic [IW-1:0]      cfg_unit,
    input  logic [SW-1:0]      cfg_slot,
    input  logic [IW-1:0]      cfg_nbr,
    input  logic [WW-1:0]      cfg_weight,
    input  logic [HW-1:0]      cfg_bias,
    input  logic [CW-1:0]      cfg_colour,
    input  logic               cfg_spin,
    output logic               spin_out
);
    import pbit_pkg::*;

    localparam logic signed [RND_W:0] T_TOP = (RND_W+1)'(TANH_TOP);

    logic [MAX_NBR-1:0][IW-1:0] idx_q;
    logic [MAX_NBR-1:0][WW-1:0] w_q;
    logic [HW-1:0]              bias_q;
    logic [CW-1:0]              colour_q;
    logic                       spin_q;

    logic                       wr_sel;
    logic                       upd_en;
    logic signed [XW-1:0]       x;
    logic signed [RND_W:0]      t;
    logic [RND_W-1:0]           rnd;
    logic signed [RND_W:0]      r_ext;
    logic                       draw;

    pbit_field #(
        .N_UNITS(N_UNITS), .MAX_NBR(MAX_NBR), .WW(WW), .HW(HW),
        .BETA_W(BETA_W), .BETA_FRAC(BETA_FRAC), .FRAC(FRAC)
    ) u_field (
        .spins_in(spins_in), .nbr_idx(idx_q), .nbr_w(w_q),
        .bias(bias_q), .beta(beta), .x(x)
    );

    pbit_tanh #(.FRAC(FRAC)) u_tanh (.x(x), .t(t));

    pbit_lfsr #(.SEED(SEED), .OUT_W(RND_W)) u_rng (
        .clk(clk), .rst_n(rst_n), .rnd(rnd)
    );

    // decode a write for this unit and this unit's commit slot
    always_comb begin
        wr_sel = cfg_we && !busy && (cfg_unit == IW'(ID));
        upd_en = busy && (phase == colour_q);
        r_ext  = {rnd[RND_W-1], rnd};
        draw   = (t > r_ext);
    end

    // hold configuration; commit the drawn spin on this unit's phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            w_q      <= '0;
            bias_q   <= '0;
            colour_q <= '0;
            spin_q   <= 1'b1;
        end else if (wr_sel) begin
            if (cfg_is_unit) begin
                bias_q   <= cfg_bias;
                colour_q <= cfg_colour;
                spin_q   <= cfg_spin;
            end else if (cfg_slot < SW'(MAX_NBR)) begin
                idx_q[cfg_slot] <= cfg_nbr;
                w_q[cfg_slot]   <= cfg_weight;
            end
        end else if (upd_en) begin
            spin_q <= draw;
        end
    end

    assign spin_out = spin_q;

    // R10
    spin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en && !wr_sel) |=> $stable(spin_q));
    // R7
    sat_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && t == T_TOP) |=> spin_q);
    // R7
    sat_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && t == -T_TOP) |=> !spin_q);
    // R4
    cfg_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !upd_en) |=> $stable(bias_q) && $stable(colour_q) && $stable(spin_q));
endmodule

// File: rtl/pbit_array.sv
// Top of the colour-phased stochastic spin array: controller plus N_UNITS units.
// Assumes a proper colouring and beta/graph held steady while a sweep runs.
module pbit_array #(
    parameter int N_UNITS   = 8,
    parameter int MAX_NBR   = 6,
    parameter int N_COL     = 4,
    parameter int WW        = 4,
    parameter int HW        = 6,
    parameter int BETA_W    = 8,
    parameter int BETA_FRAC = 4,
    parameter int FRAC      = 3,
    localparam int IW = $clog2(N_UNITS),
    localparam int SW = $clog2(MAX_NBR),
    localparam int CW = $clog2(N_COL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_is_unit,
    input  logic [IW-1:0]      cfg_unit,
    input  logic [SW-1:0]      cfg_slot,
    input  logic [IW-1:0]      cfg_nbr,
    input  logic [WW-1:0]      cfg_weight,
    input  logic [HW-1:0]      cfg_bias,
    input  logic [CW-1:0]      cfg_colour,
    input  logic               cfg_spin,
    input  logic [CW:0]        num_colours,
    input  logic [BETA_W-1:0]  beta,
    input  logic               sweep_start,
    output logic               busy,
    output logic               sweep_done,
    output logic [N_UNITS-1:0] spins
);
    logic [CW-1:0] phase;

    pbit_seq #(.N_COL(N_COL)) u_seq (
        .clk(clk), .rst_n(rst_n), .sweep_start(sweep_start),
        .num_colours(num_colours), .busy(busy), .phase(phase),
        .sweep_done(sweep_done)
    );

    // one unit per spin, each with its own seed
    for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
        localparam logic [15:0] SEED_I = (16'hACE1 ^ 16'(i * 913)) | 16'h0001;
        pbit_unit #(
            .ID(i), .N_UNITS(N_UNITS), .MAX_NBR(MAX_NBR), .N_COL(N_COL),
            .WW(WW), .HW(HW), .BETA_W(BETA_W), .BETA_FRAC(BETA_FRAC),
            .FRAC(FRAC), .SEED(SEED_I)
        ) u_unit (
            .clk(clk), .rst_n(rst_n), .spins_in(spins), .busy(busy),
            .phase(phase), .beta(beta), .cfg_we(cfg_we),
            .cfg_is_unit(cfg_is_unit), .cfg_unit(cfg_unit),
            .cfg_slot(cfg_slot), .cfg_nbr(cfg_nbr), .cfg_weight(cfg_weight),
            .cfg_bias(cfg_bias), .cfg_colour(cfg_colour),
            .cfg_spin(cfg_spin), .spin_out(spins[i])
        );
    end

    // R3
    busy_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |-> !busy);
endmodule

// File: tb/sim_pbit_array.sv
module sim_pbit_array;
    localparam int N = 8;
    localparam int K = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_is_unit = 1'b0;
    logic [2:0] cfg_unit = '0;
    logic [2:0] cfg_slot = '0;
    logic [2:0] cfg_nbr = '0;
    logic [3:0] cfg_weight = '0;
    logic [5:0] cfg_bias = '0;
    logic [1:0] cfg_colour = '0;
    logic       cfg_spin = 1'b0;
    logic [2:0] num_colours = 3'd1;
    logic [7:0] beta = '0;
    logic       sweep_start = 1'b0;
    logic       busy;
    logic       sweep_done;
    logic [N-1:0] spins;

    int total = 0;
    int bad = 0;

    int m_w   [N][K];
    int m_idx [N][K];
    int m_b   [N];
    int m_col [N];
    bit m_sp  [N];
    int m_beta;

    always #5 clk = ~clk;

    pbit_array u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_is_unit(cfg_is_unit),
        .cfg_unit(cfg_unit), .cfg_slot(cfg_slot), .cfg_nbr(cfg_nbr),
        .cfg_weight(cfg_weight), .cfg_bias(cfg_bias), .cfg_colour(cfg_colour),
        .cfg_spin(cfg_spin), .num_colours(num_colours), .beta(beta),
        .sweep_start(sweep_start), .busy(busy), .sweep_done(sweep_done),
        .spins(spins)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_vec();
        int v = 0;
        for (int i = 0; i < N; i++) if (m_sp[i]) v |= (1 << i);
        return v;
    endfunction

    task automatic wr_unit(input int u, input int b, input int c, input bit s);
        @(negedge clk);
        cfg_we = 1'b1; cfg_is_unit = 1'b1; cfg_unit = 3'(u);
        cfg_bias = 6'(b); cfg_colour = 2'(c); cfg_spin = s;
        @(negedge clk);
        cfg_we = 1'b0;
        m_b[u] = b; m_col[u] = c; m_sp[u] = s;
    endtask

    task automatic wr_nbr(input int u, input int sl, input int nb, input int w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_is_unit = 1'b0; cfg_unit = 3'(u);
        cfg_slot = 3'(sl); cfg_nbr = 3'(nb); cfg_weight = 4'(w);
        @(negedge clk);
        cfg_we = 1'b0;
        if (sl < K) begin m_idx[u][sl] = nb; m_w[u][sl] = w; end
    endtask

    task automatic clear_all();
        for (int u = 0; u < N; u++) begin
            for (int s = 0; s < K; s++) wr_nbr(u, s, 0, 0);
            wr_unit(u, 0, 0, 1'b1);
        end
    endtask

    // reference: ascending classes, each reads a snapshot taken at its start
    task automatic model_sweep(input int nc);
        bit snap [N];
        for (int c = 0; c < nc; c++) begin
            snap = m_sp;
            for (int i = 0; i < N; i++) begin
                if (m_col[i] == c) begin
                    int f = m_b[i];
                    for (int s = 0; s < K; s++)
                        f += snap[m_idx[i][s]] ? m_w[i][s] : -m_w[i][s];
                    if (f * m_beta >= 64)       m_sp[i] = 1'b1;
                    else if (f * m_beta <= -64) m_sp[i] = 1'b0;
                    else $display("bench: unpredictable field unit %0d", i);
                end
            end
        end
    endtask

    task automatic run_sweep(input int nc, input bit hold, input bit poke, output int cyc);
        @(negedge clk);
        num_colours = 3'(nc);
        sweep_start = 1'b1;
        @(negedge clk);
        sweep_start = hold;
        if (poke) begin
            cfg_we = 1'b1; cfg_is_unit = 1'b1; cfg_unit = 3'd6;
            cfg_bias = 6'd0; cfg_colour = 2'd0; cfg_spin = 1'b0;
        end
        cyc = 0;
        do begin
            @(negedge clk);
            sweep_start = 1'b0;
            cfg_we = 1'b0;
            cyc++;
        end while (!sweep_done && cyc < 50);
        @(negedge clk);
        chk(!sweep_done, "R3 done one cycle", int'(sweep_done), 0);
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(spins == '1, "R1 reset spins", int'(spins), 255);
        chk(!busy, "R1 reset busy", int'(busy), 0);
        chk(!sweep_done, "R1 reset done", int'(sweep_done), 0);

        for (int i = 0; i < N; i++) begin
            m_b[i] = 0; m_col[i] = 0; m_sp[i] = 1'b1;
            for (int s = 0; s < K; s++) begin m_w[i][s] = 0; m_idx[i][s] = 0; end
        end
        clear_all();
        // R2 preset readback and ignored out-of-range slot
        wr_unit(2, 0, 0, 1'b0);
        chk(spins == 8'hFB, "R2 preset spin", int'(spins), 251);
        wr_nbr(2, 7, 5, -8);

        // R5 R6 R7: ring graphs, saturated fields, exact sign model
        beta = 8'd255; m_beta = 255;
        for (int p = 0; p < 4; p++) begin
            int nc = (p % 2 == 0) ? 2 : 4;
            for (int i = 0; i < N; i++) begin
                wr_nbr(i, 0, (i + 7) % 8, ((i * 3 + p) % 3 == 0) ? -2 : 2);
                wr_nbr(i, 1, (i + 1) % 8, ((i + p) % 2 == 1) ? 2 : -2);
                wr_unit(i, 2 * ((i * 5 + p * 3) % 4) - 3, i % nc, ((i + p) % 3) != 0);
            end
            for (int sw = 0; sw < 3; sw++) begin
                run_sweep(nc, 1'b0, 1'b0, cyc);
                model_sweep(nc);
                // R3 cycle count
                chk(cyc == nc, "R3 sweep cycles", cyc, nc);
                // R5 R6 R7 ordered commit of field signs
                chk(int'(spins) == model_vec(), "R5 ordered spins", int'(spins), model_vec());
            end
        end

        // R8: fields far past the clamp keep their sign
        clear_all();
        for (int i = 0; i < N; i++) begin
            for (int s = 0; s < K; s++) wr_nbr(i, s, (i + 1) % 8, (i % 2 == 0) ? 7 : -8);
            wr_unit(i, (i % 2 == 0) ? 31 : -32, 0, 1'b1);
        end
        for (int sw = 0; sw < 2; sw++) begin
            run_sweep(1, 1'b0, 1'b0, cyc);
            model_sweep(1);
            chk(int'(spins) == model_vec(), "R8 clamped sign", int'(spins), model_vec());
        end

        // R10 R4: inactive colour holds, start and write during busy ignored
        clear_all();
        for (int i = 0; i < N; i++) wr_unit(i, -31, (i < 4) ? 0 : 3, 1'b1);
        run_sweep(2, 1'b1, 1'b1, cyc);
        chk(cyc == 2, "R4 restart ignored", cyc, 2);
        chk(spins[3:0] == 4'h0, "R10 active colour updated", int'(spins[3:0]), 0);
        chk(spins[7:4] == 4'hF, "R10 R4 inactive colour held", int'(spins[7:4]), 15);
        // R2 idle write takes effect
        wr_unit(6, -31, 3, 1'b0);
        chk(spins[6] == 1'b0, "R2 idle write", int'(spins[6]), 0);

        // R9 R11: stochastic statistics
        clear_all();
        for (int i = 0; i < N; i++) wr_unit(i, (i < 4) ? 0 : 1, 0, 1'b1);
        beta = 8'd16;
        begin
            int n_zero = 0;
            int n_one = 0;
            int differ = 0;
            for (int sw = 0; sw < 200; sw++) begin
                run_sweep(1, 1'b0, 1'b0, cyc);
                for (int i = 0; i < 4; i++) n_zero += int'(spins[i]);
                for (int i = 4; i < 8; i++) n_one += int'(spins[i]);
                if (spins[0] != spins[1]) differ++;
            end
            // R9 zero field: 800 draws near 400
            chk(n_zero >= 320 && n_zero <= 480, "R9 zero field fair", n_zero, 400);
            // R9 field 1.0: expected 800*225/256 = 703
            chk(n_one >= 656 && n_one <= 752, "R9 unit field bias", n_one, 703);
            // R11 separate generators
            chk(differ >= 40, "R11 independent draws", differ, 100);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule